// File: doc/BRIEF.md
# Reed-Solomon Correction Applier for a Paged Buffer

This block sits behind the decoder of a page code that works on 12-bit symbols. It corrects at most four symbols per page, using eight syndromes and fourteen spare bytes of check data. A stream of decoded corrections arrives one pair at a time. Each pair is a symbol position and a 12-bit error value. The block turns every pair into one or two byte updates on a page buffer and performs each update as a read, an XOR and a write-back. The buffer has a 2048-byte data area and a small spare area.

The symbols are packed two to three bytes, with a nibble shared between neighbours. Symbol 0 holds only eight bits. The symbol at position 1365 spans the last data byte and the first spare byte. The block applies these packing rules, throws out positions and values that cannot be real errors, and, after the last pair of a page, reports either the number of corrected symbols or a failure.

Top module: `rs_err_apply`

## Requirements
- R1: `in_ready` is high only while no update is in progress. An accepted pair that is applied keeps `in_ready` low until its last byte write is done. The buffer port returns read data in the cycle after a read request.
- R2: For an odd position p, let b = floor(3p/2). Byte b is XORed with the value's upper eight bits, and byte b+1 with the value's low nibble placed in bits 7:4.
- R3: For an even nonzero position p, let b = 3p/2. Byte b-1 is XORed with the value's upper nibble placed in bits 3:0, and byte b with the value's low eight bits.
- R4: Position 0 updates only data byte 0, with the value's low eight bits. If any of value bits 11:8 are set, the page fails and no byte is touched.
- R5: Position 1365 updates data byte 2047 (value bits 11:4) and spare byte 0 (value bits 3:0 placed in bits 7:4).
- R6: Any byte index at or above 2048 addresses the spare area (`buf_spare`=1) at index minus 2048. Spare addresses stay below 14.
- R7: A position greater than 1374 fails the page and touches no byte.
- R8: Once a page has failed, its later pairs are accepted but cause no buffer access. The final status shows failure with a count of 0.
- R9: A pair flagged `in_last` ends the page. `done` pulses for one cycle with `res_cnt` equal to the number of applied pairs. The next page starts with a zero count and no failure.
- R10: After reset, `in_ready`=1, `buf_req`=0, `done`=0, `res_fail`=0 and `res_cnt`=0.
- R11: Each byte write goes to the address read in the cycle before it and carries the read data XOR the correction mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Correction pair present |
| in_ready | output | 1 | Block can take a pair |
| in_pos | input | 11 | Symbol position |
| in_pat | input | 12 | Error value of the symbol |
| in_last | input | 1 | Final pair of the page |
| buf_req | output | 1 | Buffer access this cycle |
| buf_we | output | 1 | 1 = write, 0 = read |
| buf_spare | output | 1 | 1 = spare area, 0 = data area |
| buf_addr | output | 11 | Byte index within the selected area |
| buf_wdata | output | 8 | Write data |
| buf_rdata | input | 8 | Read data, valid one cycle after a read request |
| done | output | 1 | One-cycle page-complete pulse |
| res_fail | output | 1 | Page was uncorrectable |
| res_cnt | output | 3 | Symbols corrected on the page |

## Verification
If the latched lane or area select is wrong, the wrong byte changes in the data or spare area. This shows in the buffer contents as soon as the page's `done` pulse arrives. A wrong sequencer state shows at once as a write without a preceding read, or as `in_ready` coming back too early, in the cycles right after acceptance. A sticky failure flag that does not clear, or a count that is carried over, shows in the status of the very next page.

// File: rtl/rs_apply_pkg.sv
// Shared definitions for the correction applier.
// Assumes 12-bit symbols packed into 8-bit bytes.
package rs_apply_pkg;
    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_WR0,
        ST_RD1,
        ST_WR1
    } seq_state_e;
endpackage

// File: rtl/rs_sym_map.sv
// Maps one (position, value) pair to up to two byte updates.
// Each update has an area select, an address and an XOR mask.
// Flags pairs that make the page uncorrectable. Purely combinational.
// Assumes symbol 0 carries 8 bits and every later symbol carries 12.
module rs_sym_map
    import rs_apply_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 14,
    parameter int POS_W       = 11,
    parameter int ADDR_W      = $clog2(DATA_BYTES)
) (
    input  logic [POS_W-1:0]              pos,
    input  logic [SYM_W-1:0]              pat,
    output logic                          bad,
    output logic                          two,
    output logic [1:0]                    sp,
    output logic [1:0][ADDR_W-1:0]        addr,
    output logic [1:0][BYTE_W-1:0]        mask
);
    localparam int IDX_W   = POS_W + 2;
    localparam int MAX_POS = ((DATA_BYTES + SPARE_BYTES) * BYTE_W - BYTE_W) / SYM_W;

    logic [IDX_W-1:0] base;
    logic [1:0][IDX_W-1:0] idx;

    assign base = IDX_W'((IDX_W'(pos) * IDX_W'(3)) >> 1);

    // Byte indices and masks from the nibble packing rules
    always_comb begin
        idx  = '0;
        mask = '0;
        two  = 1'b1;
        bad  = 1'b0;
        if (pos == '0) begin
            two     = 1'b0;
            mask[0] = pat[7:0];
            bad     = |pat[11:8];
        end else if (pos[0]) begin
            idx[0]  = base;
            mask[0] = pat[11:4];
            idx[1]  = base + IDX_W'(1);
            mask[1] = {pat[3:0], 4'h0};
        end else begin
            idx[0]  = base - IDX_W'(1);
            mask[0] = {4'h0, pat[11:8]};
            idx[1]  = base;
            mask[1] = pat[7:0];
        end
        if (pos > POS_W'(MAX_POS)) bad = 1'b1;
    end

    // Area split per lane: indices past the data area fold into the spare area
    for (genvar k = 0; k < 2; k++) begin : g_lane
        always_comb begin
            sp[k]   = (idx[k] >= IDX_W'(DATA_BYTES));
            addr[k] = sp[k] ? ADDR_W'(idx[k] - IDX_W'(DATA_BYTES)) : ADDR_W'(idx[k]);
        end
    end
endmodule

// File: rtl/rs_rmw_seq.sv
// Accepts mapped pairs and runs read-XOR-write on each byte.
// Keeps the page failure and count state and issues the final status.
// Assumes buffer read data one cycle after the read request.
module rs_rmw_seq
    import rs_apply_pkg::*;
#(
    parameter int SPARE_BYTES = 14,
    parameter int ADDR_W      = 11,
    parameter int CNT_W       = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_last,
    output logic                      in_ready,
    input  logic                      map_bad,
    input  logic                      map_two,
    input  logic [1:0]                map_sp,
    input  logic [1:0][ADDR_W-1:0]    map_addr,
    input  logic [1:0][BYTE_W-1:0]    map_mask,
    output logic                      buf_req,
    output logic                      buf_we,
    output logic                      buf_spare,
    output logic [ADDR_W-1:0]         buf_addr,
    output logic [BYTE_W-1:0]         buf_wdata,
    input  logic [BYTE_W-1:0]         buf_rdata,
    output logic                      done,
    output logic                      res_fail,
    output logic [CNT_W-1:0]          res_cnt
);
    seq_state_e                 st;
    logic                       two_q, last_q, fail_q;
    logic [1:0]                 sp_q;
    logic [1:0][ADDR_W-1:0]     addr_q;
    logic [1:0][BYTE_W-1:0]     mask_q;
    logic [CNT_W-1:0]           cnt_q;
    logic                       lane, skip;

    assign in_ready  = (st == ST_IDLE);
    assign skip      = fail_q | map_bad;
    assign lane      = (st == ST_RD1) || (st == ST_WR1);
    assign buf_req   = (st != ST_IDLE);
    assign buf_we    = (st == ST_WR0) || (st == ST_WR1);
    assign buf_spare = sp_q[lane];
    assign buf_addr  = addr_q[lane];
    assign buf_wdata = buf_rdata ^ mask_q[lane];

    // Sequencer, page state and final status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            two_q    <= 1'b0;
            last_q   <= 1'b0;
            fail_q   <= 1'b0;
            sp_q     <= '0;
            addr_q   <= '0;
            mask_q   <= '0;
            cnt_q    <= '0;
            done     <= 1'b0;
            res_fail <= 1'b0;
            res_cnt  <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (in_valid) begin
                    two_q  <= map_two;
                    last_q <= in_last;
                    sp_q   <= map_sp;
                    addr_q <= map_addr;
                    mask_q <= map_mask;
                    if (skip) begin
                        if (in_last) begin
                            done     <= 1'b1;
                            res_fail <= 1'b1;
                            res_cnt  <= '0;
                            cnt_q    <= '0;
                            fail_q   <= 1'b0;
                        end else begin
                            fail_q <= 1'b1;
                        end
                    end else begin
                        st    <= ST_RD0;
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_RD0: st <= ST_WR0;
                ST_RD1: st <= ST_WR1;
                ST_WR0, ST_WR1: begin
                    if (st == ST_WR0 && two_q) begin
                        st <= ST_RD1;
                    end else begin
                        st <= ST_IDLE;
                        if (last_q) begin
                            done     <= 1'b1;
                            res_fail <= fail_q;
                            res_cnt  <= fail_q ? '0 : cnt_q;
                            cnt_q    <= '0;
                            fail_q   <= 1'b0;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1
    accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && !skip) |=> (!in_ready && buf_req && !buf_we));

    // R11
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req && !buf_we) |=> (buf_req && buf_we && $stable(buf_addr) && $stable(buf_spare)));

    // R6
    spare_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req && buf_spare) |-> (buf_addr < ADDR_W'(SPARE_BYTES)));

    // R8
    sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && fail_q) |=> !buf_req);
endmodule

// File: rtl/rs_err_apply.sv
// Top level: applies decoded symbol corrections to a paged byte buffer.
// Assumes at most MAX_PAIRS pairs per page and a one-cycle buffer read latency.
module rs_err_apply
    import rs_apply_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 14,
    parameter int POS_W       = 11,
    parameter int MAX_PAIRS   = 4,
    parameter int ADDR_W      = $clog2(DATA_BYTES),
    parameter int CNT_W       = $clog2(MAX_PAIRS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [POS_W-1:0]     in_pos,
    input  logic [SYM_W-1:0]     in_pat,
    input  logic                 in_last,
    output logic                 buf_req,
    output logic                 buf_we,
    output logic                 buf_spare,
    output logic [ADDR_W-1:0]    buf_addr,
    output logic [BYTE_W-1:0]    buf_wdata,
    input  logic [BYTE_W-1:0]    buf_rdata,
    output logic                 done,
    output logic                 res_fail,
    output logic [CNT_W-1:0]     res_cnt
);
    logic                    m_bad, m_two;
    logic [1:0]              m_sp;
    logic [1:0][ADDR_W-1:0]  m_addr;
    logic [1:0][BYTE_W-1:0]  m_mask;

    rs_sym_map #(
        .DATA_BYTES(DATA_BYTES), .SPARE_BYTES(SPARE_BYTES),
        .POS_W(POS_W), .ADDR_W(ADDR_W)
    ) u_map (
        .pos(in_pos), .pat(in_pat), .bad(m_bad), .two(m_two),
        .sp(m_sp), .addr(m_addr), .mask(m_mask)
    );

    rs_rmw_seq #(
        .SPARE_BYTES(SPARE_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .map_bad(m_bad), .map_two(m_two), .map_sp(m_sp),
        .map_addr(m_addr), .map_mask(m_mask), .buf_req(buf_req), .buf_we(buf_we),
        .buf_spare(buf_spare), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .done(done), .res_fail(res_fail), .res_cnt(res_cnt)
    );
endmodule

// File: tb/sim_rs_err_apply.sv
// Directed bench: a buffer model with one-cycle read latency and a reference model built from the requirements.
module sim_rs_err_apply;
    localparam int DB = 2048;
    localparam int SB = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [10:0] in_pos = '0;
    logic [11:0] in_pat = '0;
    logic        in_last = 1'b0;
    logic        buf_req, buf_we, buf_spare;
    logic [10:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = '0;
    logic        done, res_fail;
    logic [2:0]  res_cnt;

    logic [7:0] mem_d [DB];
    logic [7:0] mem_s [SB];
    logic [7:0] exp_d [DB];
    logic [7:0] exp_s [SB];
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rs_err_apply u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pos(in_pos), .in_pat(in_pat), .in_last(in_last), .buf_req(buf_req),
        .buf_we(buf_we), .buf_spare(buf_spare), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .done(done),
        .res_fail(res_fail), .res_cnt(res_cnt)
    );

    // Buffer model: write on the edge, read data the cycle after the request
    always @(posedge clk) begin
        if (buf_req) begin
            if (buf_we) begin
                if (buf_spare) begin
                    if (buf_addr < 11'(SB)) mem_s[buf_addr] <= buf_wdata;
                end else mem_d[buf_addr] <= buf_wdata;
            end else begin
                buf_rdata <= buf_spare ? ((buf_addr < 11'(SB)) ? mem_s[buf_addr] : 8'h00)
                                       : mem_d[buf_addr];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input int v);
        if (idx < DB) exp_d[idx] ^= 8'(v);
        else exp_s[idx - DB] ^= 8'(v);
    endtask

    // Reference model written from R2..R7
    task automatic ref_apply(input int p, input int v, inout bit f);
        int b;
        if (f) return;
        if (p > 1374) begin f = 1; return; end
        if (p == 0) begin
            if ((v >> 8) != 0) f = 1;
            else put(0, v & 255);
            return;
        end
        b = (3 * p) / 2;
        if (p % 2 == 1) begin
            put(b, v >> 4);
            put(b + 1, (v & 15) << 4);
        end else begin
            put(b - 1, v >> 8);
            put(b, v & 255);
        end
    endtask

    task automatic send(input int p, input int v, input bit last);
        int g = 0;
        @(negedge clk);
        while (!in_ready && g < 100) begin @(negedge clk); g++; end
        in_pos = 11'(p); in_pat = 12'(v); in_last = last; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int g = 0;
        while (!done && g < 200) begin @(negedge clk); g++; end
        chk({req, " done pulse"}, int'(done), 1);
    endtask

    task automatic cmp_mem(input string req);
        int md = 0, ms = 0;
        for (int i = 0; i < DB; i++) if (mem_d[i] !== exp_d[i]) md++;
        for (int i = 0; i < SB; i++) if (mem_s[i] !== exp_s[i]) ms++;
        chk({req, " data area mismatches"}, md, 0);
        chk({req, " spare area mismatches"}, ms, 0);
    endtask

    task automatic run_page(input string req, input int n, input int ps[4], input int vs[4]);
        bit f = 0;
        for (int k = 0; k < n; k++) begin
            ref_apply(ps[k], vs[k], f);
            send(ps[k], vs[k], k == n - 1);
        end
        wait_done(req);
        chk({req, " fail flag"}, int'(res_fail), int'(f));
        chk({req, " count"}, int'(res_cnt), f ? 0 : n);
        cmp_mem(req);
    endtask

    task automatic t_reset;
        chk("R10 in_ready", int'(in_ready), 1);
        chk("R10 buf_req", int'(buf_req), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 res_fail", int'(res_fail), 0);
        chk("R10 res_cnt", int'(res_cnt), 0);
    endtask

    task automatic t_handshake;
        bit f = 0;
        ref_apply(7, 'h3C5, f);
        @(negedge clk);
        in_pos = 11'd7; in_pat = 12'h3C5; in_last = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk("R1 ready low during update", int'(in_ready), 0);
        chk("R11 first access is a read", int'(buf_req && !buf_we), 1);
        chk("R11 read address", int'(buf_addr), 10);
        @(negedge clk);
        chk("R11 write follows read", int'(buf_req && buf_we), 1);
        chk("R11 write data", int'(buf_wdata), int'(mem_d[10] ^ 8'h3C));
        @(negedge clk);
        chk("R1 second read", int'(buf_req && !buf_we && buf_addr == 11'd11), 1);
        @(negedge clk);
        chk("R11 second write", int'(buf_req && buf_we), 1);
        @(negedge clk);
        chk("R1 ready back after four cycles", int'(in_ready), 1);
        chk("R9 done with last write", int'(done), 1);
        chk("R9 count", int'(res_cnt), 1);
        @(negedge clk);
        chk("R9 done is one cycle", int'(done), 0);
        cmp_mem("R11");
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DB; i++) begin mem_d[i] = 8'(i * 7 + 3); exp_d[i] = 8'(i * 7 + 3); end
        for (int i = 0; i < SB; i++) begin mem_s[i] = 8'(i * 29 + 5); exp_s[i] = 8'(i * 29 + 5); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        run_page("R2 odd position", 1, '{5, 0, 0, 0}, '{'hABC, 0, 0, 0});
        run_page("R3 even position", 1, '{4, 0, 0, 0}, '{'h5A3, 0, 0, 0});
        run_page("R4 position zero ok", 1, '{0, 0, 0, 0}, '{'h0FF, 0, 0, 0});
        run_page("R4 position zero bad", 1, '{0, 0, 0, 0}, '{'h1FF, 0, 0, 0});
        run_page("R5 straddle", 1, '{1365, 0, 0, 0}, '{'h9E7, 0, 0, 0});
        run_page("R6 spare area", 2, '{1373, 1374, 0, 0}, '{'h123, 'h456, 0, 0});
        run_page("R7 out of range", 1, '{1375, 0, 0, 0}, '{'h001, 0, 0, 0});
        run_page("R7 far out of range", 1, '{2047, 0, 0, 0}, '{'hFFF, 0, 0, 0});
        run_page("R8 sticky failure", 3, '{1400, 10, 1365, 0}, '{'h010, 'hFFF, 'h0F0, 0});
        run_page("R9 four pairs", 4, '{1, 2, 700, 1366}, '{'hFFF, 'h801, 'h5A5, 'hC3C});
        run_page("R9 fresh page after fail", 1, '{3, 0, 0, 0}, '{'h777, 0, 0, 0});
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule